// File: doc/BRIEF.md
# Programmable-Latency Cache RAM Sequencer

This block sits between cache controller logic and a synchronous RAM array, such as a tag store or a data store. It takes one read or write at a time over a request/ready handshake. It drives the RAM address, write data and write strobe from registers. It then times the access against three programmable latencies: setup, read and write recovery.

The RAM may be clocked at an integer fraction of the controller clock. The `ram_ce` input is high in the controller cycles that end on a RAM clock edge. Every latency is counted in those cycles only. The per-bank enable output `ram_clk_en` rises only in the single RAM cycle that performs the access, so an external gating cell can keep the RAM clock stopped at all other times. With the default of four banks, the two low address bits pick one bank. That bank alone is clocked, and read data is taken from that bank's slice of the read bus. All banks share one set of latencies.

Top module: `cache_ram_sequencer`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. It is high after reset, and it is low in the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge).
- R2: From the cycle after acceptance until the access edge, `ram_addr`, `ram_wdata` and `ram_we` hold the accepted request's values without change.
- R3: With setup field S (3 bits, 0 to 7), the access edge falls on the (S+1)-th cycle with `ram_ce` high, counted strictly after the acceptance cycle.
- R4: `ram_clk_en` is nonzero in exactly one cycle per access. That cycle is the access edge, and `ram_ce` is high in it.
- R5: For a read with read field R (3 bits), data is captured at the end of the (R+1)-th `ram_ce` cycle after the access edge. `rd_valid` is then high for exactly one controller cycle, with the captured value on `rd_data`.
- R6: For a write with recovery field W (3 bits), `req_ready` stays low for exactly W `ram_ce` cycles after the write edge, and rises in the cycle after the W-th one. With W=0, it rises in the cycle right after the edge.
- R7: Latency counts advance only in cycles with `ram_ce` high. For clock ratios of 1, 2 and 3, the R3, R5 and R6 counts hold in RAM cycles, whatever the number of controller cycles between them.
- R8: With four banks, the bank is `req_addr[1:0]` and only bit `req_addr[1:0]` of `ram_clk_en` is driven. Read data comes from `ram_rdata[16*bank +: 16]`.
- R9: The three latency fields are sampled at acceptance. Changing `cfg_setup`, `cfg_rd_lat` or `cfg_wr_lat` while an access is in progress does not alter that access's timing.
- R10: During and right after synchronous reset, `rd_valid` is low, `ram_clk_en` is zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ram_ce | input | 1 | High in controller cycles that end on a RAM clock edge |
| cfg_setup | input | 3 | Extra RAM cycles of setup before the access edge |
| cfg_rd_lat | input | 3 | Extra RAM cycles before read data is valid |
| cfg_wr_lat | input | 3 | Extra RAM cycles of recovery after a write edge |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Access address; low bits select the bank |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Captured read data |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_clk_en | output | 4 | Per-bank clock enable, high only on the access edge |
| ram_rdata | input | 64 | Read data of all banks, bank b in bits 16*b+15:16*b |

## Verification
A wrong count in the shared latency counter shows up at once as a shifted access edge, or as a shifted rise of `rd_valid` or `req_ready`. The error is one RAM cycle long, which is `ratio` controller cycles, and it appears within the same access. A capture taken too early returns the bank model's poison value rather than the stored word, so an off-by-one in the read wait shows in the data as well as in the timing. A wrong bank decode shows as the wrong `ram_clk_en` bit on the edge cycle. A counter that also advances on cycles with the clock enable low is exposed only when the ratio is above one, so the sweep covers ratios 1 to 3.

// File: rtl/ram_seq_pkg.sv
// Package: shared state type for the cache RAM sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ram_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for a request
        ST_SETUP  = 2'd1,   // outputs held, counting setup, edge when count hits zero
        ST_RDWAIT = 2'd2,   // counting read latency before capture
        ST_WREC   = 2'd3    // counting write recovery before going idle
    } seq_state_t;

endpackage

// File: rtl/ram_seq_counter.sv
// Module: down counter for latency windows, advancing on RAM-clock cycles only.
// Assumes: load has priority over tick; the count stops at zero.
module ram_seq_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         is_zero
);

    logic [W-1:0] cnt;

    // Purpose: load a new window or step one RAM cycle towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign is_zero = (cnt == '0);

    // R7: without a load, the count may only move on a RAM-clock cycle
    p_count_on_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

    // R3: without a load, the count never grows
    p_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/ram_seq_bank_dec.sv
// Module: turns a bank index and an access strobe into per-bank clock enables.
// Assumes: NUM_BANKS is a power of two; a single bank ignores the index.
module ram_seq_bank_dec #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [BANK_W-1:0]    bank_idx,
    input  logic                 fire,
    output logic [NUM_BANKS-1:0] en_o
);

    generate
        if (NUM_BANKS > 1) begin : g_banked
            for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bit
                // Purpose: enable bank i only when it is the addressed one.
                assign en_o[i] = fire && (bank_idx == BANK_W'(i));
            end
        end else begin : g_single
            logic unused_idx;
            assign unused_idx = ^bank_idx;
            // Purpose: a single array is clocked on every access edge.
            assign en_o[0] = fire;
        end
    endgenerate

    // R8: at most one bank is clocked at a time
    always_comb begin
        p_one_bank_r8: assert ($onehot0(en_o)) else $error("more than one bank enabled");
    end

endmodule

// File: rtl/cache_ram_sequencer.sv
// Module: sequences single read/write accesses to a synchronous RAM with
// programmable setup, read and write-recovery latencies counted in RAM cycles.
// Assumes: ram_ce marks controller cycles ending on a RAM edge (integer ratio);
// the external gating cell clocks a bank only when its ram_clk_en bit is high.
module cache_ram_sequencer
    import ram_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int LAT_W     = 3,
    parameter int NUM_BANKS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ram_ce,
    input  logic [LAT_W-1:0]            cfg_setup,
    input  logic [LAT_W-1:0]            cfg_rd_lat,
    input  logic [LAT_W-1:0]            cfg_wr_lat,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [ADDR_W-1:0]           ram_addr,
    output logic [DATA_W-1:0]           ram_wdata,
    output logic                        ram_we,
    output logic [NUM_BANKS-1:0]        ram_clk_en,
    input  logic [NUM_BANKS*DATA_W-1:0] ram_rdata
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    seq_state_t         state;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               we_q;
    logic [LAT_W-1:0]   rd_lat_q;
    logic [LAT_W-1:0]   wr_lat_q;
    logic [BANK_W-1:0]  bank_q;
    logic               accept;
    logic               edge_now;
    logic               done_wait;
    logic               cnt_zero;
    logic               cnt_load;
    logic [LAT_W-1:0]   cnt_val;
    logic [DATA_W-1:0]  bank_rd [NUM_BANKS];

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign edge_now  = (state == ST_SETUP) && cnt_zero && ram_ce;
    assign done_wait = cnt_zero && ram_ce;

    // Purpose: pick the counter window to load at acceptance and at the edge.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (accept) begin
            cnt_load = 1'b1;
            cnt_val  = cfg_setup;
        end else if (edge_now) begin
            cnt_load = 1'b1;
            cnt_val  = we_q ? (wr_lat_q - LAT_W'(1)) : rd_lat_q;
        end
    end

    ram_seq_counter #(.W(LAT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (ram_ce),
        .is_zero  (cnt_zero)
    );

    // Purpose: latch the request and its latency fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            rd_lat_q <= '0;
            wr_lat_q <= '0;
            bank_q   <= '0;
        end else if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            we_q     <= req_write;
            rd_lat_q <= cfg_rd_lat;
            wr_lat_q <= cfg_wr_lat;
            bank_q   <= (NUM_BANKS > 1) ? req_addr[BANK_W-1:0] : '0;
        end
    end

    // Purpose: step the access through setup, edge, read wait or write recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (accept) state <= ST_SETUP;
                ST_SETUP:  if (edge_now)
                               state <= !we_q ? ST_RDWAIT :
                                        (wr_lat_q == '0) ? ST_IDLE : ST_WREC;
                ST_RDWAIT: if (done_wait) state <= ST_IDLE;
                ST_WREC:   if (done_wait) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rd
            // Purpose: split the flat read bus into one word per bank.
            assign bank_rd[b] = ram_rdata[b*DATA_W +: DATA_W];
        end
    endgenerate

    // Purpose: capture the addressed bank's word when the read wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_RDWAIT) && done_wait;
            if ((state == ST_RDWAIT) && done_wait)
                rd_data <= bank_rd[bank_q];
        end
    end

    ram_seq_bank_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
        .bank_idx (bank_q),
        .fire     (edge_now),
        .en_o     (ram_clk_en)
    );

    assign ram_addr  = addr_q;
    assign ram_wdata = wdata_q;
    assign ram_we    = we_q;

    // R1: an accepted request makes the sequencer busy on the next cycle
    p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: RAM-side outputs are frozen while setup is counted
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && $past(state == ST_SETUP))
            |-> ($stable(ram_addr) && $stable(ram_wdata) && $stable(ram_we)));

    // R4: after the edge the sequencer leaves setup, so the edge is single
    p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_clk_en != '0) |=> (state != ST_SETUP));

    // R5: read-valid lasts one controller cycle
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: no bank is clocked during write recovery
    p_quiet_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WREC) |-> (ram_clk_en == '0));

endmodule

// File: tb/tb_cache_ram_sequencer.sv
`timescale 1ns/1ps
module tb_cache_ram_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_ce = 1'b0;
    logic [2:0]  cfg_setup = '0, cfg_rd_lat = '0, cfg_wr_lat = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rd_valid, ram_we;
    logic [15:0] rd_data, ram_wdata;
    logic [7:0]  ram_addr;
    logic [3:0]  ram_clk_en;
    logic [63:0] ram_rdata;

    int tests = 0, fails = 0;
    int ratio = 1;
    int model_r = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cache_ram_sequencer dut (
        .clk(clk), .rst_n(rst_n), .ram_ce(ram_ce),
        .cfg_setup(cfg_setup), .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_clk_en(ram_clk_en), .ram_rdata(ram_rdata)
    );

    // RAM clock-enable pattern: one cycle in every `ratio`, changed after the edge
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            ph = (ph + 1 >= ratio) ? 0 : ph + 1;
            ram_ce <= (ph == ratio - 1);
        end
    end

    // Bank model: stores writes, returns poison until the read latency has passed
    logic [15:0] mem [256];
    int          ticks = 0;
    logic [7:0]  rd_addr_m = '0;
    logic [1:0]  rd_bank_m = '0;

    always @(posedge clk) begin
        if (ram_clk_en != 4'b0) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else begin
                ticks     <= 0;
                rd_addr_m <= ram_addr;
                rd_bank_m <= ram_addr[1:0];
            end
        end else if (ram_ce && ticks < 100) ticks <= ticks + 1;
    end

    always_comb begin
        for (int b = 0; b < 4; b++)
            ram_rdata[b*16 +: 16] = (b == int'(rd_bank_m) && ticks >= model_r)
                                    ? mem[rd_addr_m] : (16'hBAD0 | 16'(b));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic access(input bit we, input logic [7:0] a, input logic [15:0] wd,
                          input int s, input int lat, input logic [15:0] exp_rd);
        int n;
        int guard;
        @(negedge clk);
        cfg_setup  = 3'(s);
        cfg_rd_lat = 3'(lat);
        cfg_wr_lat = 3'(lat);
        model_r    = lat;
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
        chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        // R9: disturb the fields right after acceptance
        cfg_setup = ~3'(s); cfg_rd_lat = ~3'(lat); cfg_wr_lat = ~3'(lat);
        chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
        n = 0; guard = 0;
        forever begin
            if (ram_ce) n++;
            chk(ram_addr == a && ram_wdata == wd && ram_we == we, "R2 outputs held",
                int'(ram_addr), int'(a));
            if (ram_clk_en != 4'b0) begin
                chk(ram_ce == 1'b1, "R4 enable only with ce", ram_ce, 1);
                chk(n == s + 1, "R3/R7/R9 setup ce count", n, s + 1);
                chk(ram_clk_en == (4'b1 << a[1:0]), "R8 bank enable", ram_clk_en,
                    int'(4'b1 << a[1:0]));
                break;
            end
            guard++;
            if (guard > 100) begin chk(1'b0, "R4 no access edge", 0, 1); break; end
            @(negedge clk);
        end
        n = 0; guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (guard > 100) begin chk(1'b0, "R5/R6 no completion", 0, 1); break; end
            if (we) begin
                if (req_ready) begin
                    chk(n == lat, "R6/R7/R9 write recovery ce count", n, lat);
                    break;
                end
            end else if (rd_valid) begin
                chk(n == lat + 1, "R5/R7/R9 read capture ce count", n, lat + 1);
                chk(rd_data == exp_rd, "R5/R8 read data", rd_data, exp_rd);
                break;
            end
            chk(ram_clk_en == 4'b0, "R4 single enable per access", ram_clk_en, 0);
            if (ram_ce) n++;
        end
        if (!we) begin
            @(negedge clk);
            chk(rd_valid == 1'b0, "R5 one-cycle pulse", rd_valid, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
        chk(rd_valid == 1'b0, "R10 no read valid in reset", rd_valid, 0);
        chk(ram_clk_en == 4'b0, "R10 no enable in reset", ram_clk_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rd_valid == 1'b0 && ram_clk_en == 4'b0,
            "R10 idle after reset", req_ready, 1);
        for (int r = 1; r <= 3; r++) begin
            ratio = r;
            repeat (4) @(negedge clk);
            for (int s = 0; s < 8; s++) begin
                for (int l = 0; l < 8; l++) begin
                    logic [7:0]  a;
                    logic [15:0] wd;
                    a  = 8'((r * 64 + s * 8 + l) & 255);
                    wd = (16'(a) * 16'h0101) ^ 16'h5A3C;
                    access(1'b1, a, wd, s, l, 16'h0);
                    access(1'b0, a, 16'h0, (s + 3) % 8, l, wd);
                end
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule